// File: doc/BRIEF.md
# NAND Page Hamming Code Generator

This block sits beside a NAND flash data path. It watches each byte that crosses the interface and builds a Hamming code for every 256-byte chunk. The code is three bytes long and can locate and fix one flipped bit in its chunk. With the default setting, two chunks (a 512-byte page) are covered, and their two codes are held side by side.

Software steers the block through a 2-bit mode field. The code for a new page is started by entering clear mode, then off mode, then accumulate mode. The finished code is fetched by entering off mode, then read mode, issuing one read strobe per byte, and then returning to off mode. The read-out order is fixed and not sequential: within each code, byte 1 comes first, then byte 0, then byte 2. The codes follow one another in chunk order. Correction of the data is done elsewhere, using these codes.

Top module: `nand_ecc_gen`

## Requirements
- R1: After the reset input is released, every one of the 6 code bytes reads 8'hFF, and the first read-out position is code 0, slot 0.
- R2: A byte is accumulated only when three conditions hold together: modeSel is 2'b01, dataStrobe is high, and both cleIn and aleIn are low. A byte sent with cleIn or aleIn high changes neither the code nor the byte position.
- R3: Column parity CP[5:0] of a chunk is the XOR over all its bytes of the following bit groups: CP0 covers bits 0,2,4,6; CP1 covers bits 1,3,5,7; CP2 covers bits 0,1,4,5; CP3 covers bits 2,3,6,7; CP4 covers bits 0-3; CP5 covers bits 4-7.
- R4: Line parity LP[15:0] is built from each byte's XOR of all eight bits (its byte parity). For each bit k (0..7) of the byte's index within its chunk, that parity toggles LP[2k] when the index bit is 0, and LP[2k+1] when the index bit is 1.
- R5: The three code bytes are stored inverted: byte 0 = ~LP[7:0], byte 1 = ~LP[15:8], byte 2 = {~CP[5:0], 2'b11}.
- R6: Accumulated bytes 0-255 go to code 0 and bytes 256-511 go to code 1. Any byte beyond NUM_CODES*256 is ignored.
- R7: While modeSel is 2'b10, each readStrobe moves eccByte to the next value of this sequence: code 0 byte 1, byte 0, byte 2, then code 1 byte 1, byte 0, byte 2. After the last value, the sequence wraps to the start.
- R8: readStrobe has no effect unless modeSel is 2'b10.
- R9: One cycle with modeSel at 2'b11 clears all parity, the byte position and the read-out position.
- R10: While modeSel is 2'b00, data bytes are ignored and the output holds its value.
- R11: Flipping one data bit in a chunk changes exactly 11 of the 22 parity bits of that chunk's code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 2 | 00 off, 01 accumulate, 10 read out, 11 clear |
| cleIn | input | 1 | Command latch phase of the current transfer |
| aleIn | input | 1 | Address latch phase of the current transfer |
| dataStrobe | input | 1 | One byte is crossing the interface this cycle |
| dataByte | input | 8 | The byte crossing the interface |
| readStrobe | input | 1 | Consume the current code byte |
| eccByte | output | 8 | Code byte at the current read-out position |

## Verification
Parity is only visible through the read-out path, so a wrong parity bit stays hidden until the code is fetched. It then shows as a single wrong byte in a known slot. A byte position that has slipped spreads errors across many line parity bits, and can move parity into the wrong code. A read-out position that has slipped shows at once as bytes in the wrong order. Because the output comes straight from the registers, the effect of a stray strobe shows one cycle later. Each scenario therefore fetches the whole code after its stimulus, so that every internal register is compared against the computed value.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  localparam int IDX_W       = 8;
  localparam int CHUNK_BYTES = 1 << IDX_W;
  localparam int LP_W        = 2 * IDX_W;
  localparam int CP_W        = 6;
  localparam int SLOTS       = 3;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_ACCUM = 2'b01,
    MODE_READ  = 2'b10,
    MODE_CLEAR = 2'b11
  } eccMode_t;

  typedef struct packed {
    logic             clearAll;
    logic             accumEn;
    logic [IDX_W-1:0] byteIdx;
  } ctrlStrobes_t;

endpackage

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl
  import nand_ecc_pkg::*;
#(
  parameter  int NUM_CODES = 2,
  localparam int LIMIT     = NUM_CODES * CHUNK_BYTES,
  localparam int CNT_W     = $clog2(LIMIT + 1),
  localparam int CODE_W    = (NUM_CODES > 1) ? $clog2(NUM_CODES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         modeSel,
  input  logic               cleIn,
  input  logic               aleIn,
  input  logic               dataStrobe,
  input  logic               readStrobe,
  output ctrlStrobes_t       strobes,
  output logic [CODE_W-1:0]  chunkSel,
  output logic [CODE_W-1:0]  rdCode,
  output logic [1:0]         rdSlot,
  output logic [CNT_W-1:0]   byteCount
);

  eccMode_t mode;
  logic     notFull;
  logic     advance;

  assign mode    = eccMode_t'(modeSel);
  assign notFull = (byteCount < CNT_W'(LIMIT));
  assign advance = (mode == MODE_READ) && readStrobe;

  always_comb begin
    strobes.clearAll = (mode == MODE_CLEAR);
    strobes.accumEn  = (mode == MODE_ACCUM) && dataStrobe && !cleIn && !aleIn && notFull;
    strobes.byteIdx  = byteCount[IDX_W-1:0];
  end

  assign chunkSel = CODE_W'(byteCount >> IDX_W);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCount <= '0;
    end else if (strobes.clearAll) begin
      byteCount <= '0;
    end else if (strobes.accumEn) begin
      byteCount <= byteCount + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdCode <= '0;
      rdSlot <= '0;
    end else if (strobes.clearAll) begin
      rdCode <= '0;
      rdSlot <= '0;
    end else if (advance) begin
      if (rdSlot == 2'(SLOTS - 1)) begin
        rdSlot <= '0;
        rdCode <= (rdCode == CODE_W'(NUM_CODES - 1)) ? '0 : rdCode + 1'b1;
      end else begin
        rdSlot <= rdSlot + 1'b1;
      end
    end
  end

endmodule

// File: rtl/nand_ecc_datapath.sv
module nand_ecc_datapath
  import nand_ecc_pkg::*;
#(
  parameter  int NUM_CODES = 2,
  localparam int CODE_W    = (NUM_CODES > 1) ? $clog2(NUM_CODES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [CODE_W-1:0] chunkSel,
  input  logic [7:0]        dataByte,
  input  logic [CODE_W-1:0] rdCode,
  input  logic [1:0]        rdSlot,
  output logic [7:0]        eccByte
);

  logic [LP_W-1:0] lineReg [NUM_CODES];
  logic [CP_W-1:0] colReg  [NUM_CODES];
  logic [LP_W-1:0] lineMix;
  logic [CP_W-1:0] colMix;
  logic            bytePar;

  assign bytePar = ^dataByte;

  assign colMix = { ^(dataByte & 8'hF0), ^(dataByte & 8'h0F),
                    ^(dataByte & 8'hCC), ^(dataByte & 8'h33),
                    ^(dataByte & 8'hAA), ^(dataByte & 8'h55) };

  always_comb begin
    for (int k = 0; k < IDX_W; k++) begin
      lineMix[2*k]   = bytePar & ~strobes.byteIdx[k];
      lineMix[2*k+1] = bytePar &  strobes.byteIdx[k];
    end
  end

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
    logic hit;
    assign hit = strobes.accumEn && (chunkSel == CODE_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lineReg[g] <= '0;
        colReg[g]  <= '0;
      end else if (strobes.clearAll) begin
        lineReg[g] <= '0;
        colReg[g]  <= '0;
      end else if (hit) begin
        lineReg[g] <= lineReg[g] ^ lineMix;
        colReg[g]  <= colReg[g] ^ colMix;
      end
    end
  end

  logic [LP_W-1:0] selLine;
  logic [CP_W-1:0] selCol;

  always_comb begin
    selLine = '0;
    selCol  = '0;
    for (int c = 0; c < NUM_CODES; c++) begin
      if (rdCode == CODE_W'(c)) begin
        selLine = lineReg[c];
        selCol  = colReg[c];
      end
    end
    unique case (rdSlot)
      2'd0:    eccByte = ~selLine[15:8];
      2'd1:    eccByte = ~selLine[7:0];
      default: eccByte = {~selCol, 2'b11};
    endcase
  end

endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
  import nand_ecc_pkg::*;
#(
  parameter int NUM_CODES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       cleIn,
  input  logic       aleIn,
  input  logic       dataStrobe,
  input  logic [7:0] dataByte,
  input  logic       readStrobe,
  output logic [7:0] eccByte
);

  localparam int LIMIT  = NUM_CODES * CHUNK_BYTES;
  localparam int CNT_W  = $clog2(LIMIT + 1);
  localparam int CODE_W = (NUM_CODES > 1) ? $clog2(NUM_CODES) : 1;

  ctrlStrobes_t      strobes;
  logic [CODE_W-1:0] chunkSel;
  logic [CODE_W-1:0] rdCode;
  logic [1:0]        rdSlot;
  logic [CNT_W-1:0]  byteCount;

  nand_ecc_ctrl #(.NUM_CODES(NUM_CODES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeSel    (modeSel),
    .cleIn      (cleIn),
    .aleIn      (aleIn),
    .dataStrobe (dataStrobe),
    .readStrobe (readStrobe),
    .strobes    (strobes),
    .chunkSel   (chunkSel),
    .rdCode     (rdCode),
    .rdSlot     (rdSlot),
    .byteCount  (byteCount)
  );

  nand_ecc_datapath #(.NUM_CODES(NUM_CODES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .chunkSel (chunkSel),
    .dataByte (dataByte),
    .rdCode   (rdCode),
    .rdSlot   (rdSlot),
    .eccByte  (eccByte)
  );

endmodule

// File: rtl/nand_ecc_gen_chk.sv
module nand_ecc_gen_chk #(
  parameter  int NUM_CODES = 2,
  localparam int LIMIT     = NUM_CODES * 256,
  localparam int CNT_W     = $clog2(LIMIT + 1),
  localparam int CODE_W    = (NUM_CODES > 1) ? $clog2(NUM_CODES) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        modeSel,
  input logic              cleIn,
  input logic              aleIn,
  input logic              readStrobe,
  input logic [7:0]        eccByte,
  input logic [CNT_W-1:0]  byteCount,
  input logic [CODE_W-1:0] rdCode,
  input logic [1:0]        rdSlot
);

  // R9
  clear_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeSel == 2'b11 |=> (byteCount == '0 && rdCode == '0 && rdSlot == 2'd0 && eccByte == 8'hFF));

  // R2
  ctl_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((cleIn || aleIn) && modeSel != 2'b11) |=> $stable(byteCount));

  // R8
  read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != 2'b11 && !(modeSel == 2'b10 && readStrobe)) |=> ($stable(rdCode) && $stable(rdSlot)));

  // R10
  off_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeSel == 2'b00 |=> $stable(eccByte));

  // R6
  count_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteCount <= CNT_W'(LIMIT));

  // R7
  slot_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdSlot <= 2'd2) && (int'(rdCode) < NUM_CODES));

  // R7
  slot_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b10 && readStrobe && rdSlot != 2'd2) |=> (rdSlot == $past(rdSlot) + 2'd1));

endmodule

bind nand_ecc_gen nand_ecc_gen_chk #(.NUM_CODES(NUM_CODES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .modeSel    (modeSel),
  .cleIn      (cleIn),
  .aleIn      (aleIn),
  .readStrobe (readStrobe),
  .eccByte    (eccByte),
  .byteCount  (byteCount),
  .rdCode     (rdCode),
  .rdSlot     (rdSlot)
);

// File: tb/nand_ecc_gen_bench.sv
`timescale 1ns/1ps
module nand_ecc_gen_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic       cleIn = 1'b0;
  logic       aleIn = 1'b0;
  logic       dataStrobe = 1'b0;
  logic [7:0] dataByte = 8'h00;
  logic       readStrobe = 1'b0;
  logic [7:0] eccByte;

  int total = 0;
  int bad = 0;

  logic [15:0] refLp [2];
  logic [5:0]  refCp [2];
  int          refCount = 0;

  always #2.5 clk = ~clk;

  nand_ecc_gen u_nand_ecc_gen (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .cleIn(cleIn), .aleIn(aleIn),
    .dataStrobe(dataStrobe), .dataByte(dataByte), .readStrobe(readStrobe),
    .eccByte(eccByte)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] expByte(input int c, input int s);
    if (s == 0) return ~refLp[c][15:8];
    if (s == 1) return ~refLp[c][7:0];
    return {~refCp[c], 2'b11};
  endfunction

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 37) + (seed * 11) + (i >> 3));
  endfunction

  task automatic refClear();
    for (int c = 0; c < 2; c++) begin
      refLp[c] = '0;
      refCp[c] = '0;
    end
    refCount = 0;
  endtask

  // reference per R3, R4, R6
  task automatic refAdd(input logic [7:0] b);
    int c;
    logic [7:0] idx;
    logic bp;
    if (refCount >= 512) return;
    c   = refCount / 256;
    idx = 8'(refCount % 256);
    bp  = ^b;
    for (int k = 0; k < 8; k++) begin
      if (idx[k]) refLp[c][2*k+1] ^= bp;
      else        refLp[c][2*k]   ^= bp;
    end
    for (int j = 0; j < 3; j++)
      for (int p = 0; p < 8; p++) begin
        if ((p >> j) & 1) refCp[c][2*j+1] ^= b[p];
        else              refCp[c][2*j]   ^= b[p];
      end
    refCount++;
  endtask

  task automatic setMode(input logic [1:0] m);
    modeSel = m;
    @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic cle, input logic ale);
    dataStrobe = 1'b1;
    dataByte   = b;
    cleIn      = cle;
    aleIn      = ale;
    @(negedge clk);
    dataStrobe = 1'b0;
    cleIn      = 1'b0;
    aleIn      = 1'b0;
  endtask

  task automatic pulseRead();
    readStrobe = 1'b1;
    @(negedge clk);
    readStrobe = 1'b0;
  endtask

  task automatic startChunk();
    setMode(2'b11);
    setMode(2'b00);
    setMode(2'b01);
    refClear();
  endtask

  task automatic enterRead();
    setMode(2'b00);
    setMode(2'b10);
  endtask

  task automatic readAll(input string req);
    for (int i = 0; i < 6; i++) begin
      check(req, eccByte, expByte(i / 3, i % 3));
      pulseRead();
    end
  endtask

  task automatic feedPattern(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      sendByte(pat(i, seed), 1'b0, 1'b0);
      refAdd(pat(i, seed));
    end
  endtask

  // R1
  task automatic testReset();
    refClear();
    setMode(2'b10);
    readAll("R1 reset code bytes");
    setMode(2'b00);
  endtask

  // R3 R4 R5 R6 R7
  task automatic testFullPage();
    startChunk();
    feedPattern(512, 3);
    enterRead();
    readAll("R3_R4_R5 page code");
    setMode(2'b01);
    for (int i = 0; i < 5; i++) sendByte(8'hA5 + 8'(i), 1'b0, 1'b0);
    enterRead();
    readAll("R6 bytes past page ignored");
    check("R7 wrap to first byte", eccByte, expByte(0, 0));
    setMode(2'b00);
  endtask

  // R6 second chunk routing with partial fill
  task automatic testPartial();
    startChunk();
    feedPattern(300, 9);
    enterRead();
    readAll("R6 partial second chunk");
    setMode(2'b00);
  endtask

  // R2 R10
  task automatic testIgnored();
    startChunk();
    sendByte(8'h5A, 1'b1, 1'b0);
    sendByte(8'h3C, 1'b0, 1'b1);
    sendByte(8'h77, 1'b1, 1'b1);
    setMode(2'b00);
    sendByte(8'h81, 1'b0, 1'b0);
    check("R10 off mode output held", eccByte, 8'hFF);
    setMode(2'b10);
    sendByte(8'h42, 1'b0, 1'b0);
    setMode(2'b01);
    sendByte(8'h01, 1'b0, 1'b0);
    refAdd(8'h01);
    enterRead();
    readAll("R2 only data bytes at index 0");
    setMode(2'b00);
  endtask

  // R8
  task automatic testStrayRead();
    startChunk();
    feedPattern(40, 5);
    setMode(2'b00);
    pulseRead();
    pulseRead();
    setMode(2'b01);
    pulseRead();
    sendByte(pat(40, 5), 1'b0, 1'b0);
    refAdd(pat(40, 5));
    enterRead();
    check("R8 stray strobes ignored", eccByte, expByte(0, 0));
    readAll("R8 full code after stray strobes");
    setMode(2'b00);
  endtask

  // R9
  task automatic testClearMidRead();
    startChunk();
    feedPattern(256, 7);
    enterRead();
    pulseRead();
    pulseRead();
    check("R7 third slot is byte 2", eccByte, expByte(0, 2));
    setMode(2'b11);
    refClear();
    setMode(2'b10);
    check("R9 clear resets pointer and parity", eccByte, 8'hFF);
    readAll("R9 all bytes cleared");
    setMode(2'b00);
  endtask

  // R11
  task automatic testSingleFlip();
    logic [7:0] codeA [3];
    logic [7:0] codeB [3];
    int diff;
    startChunk();
    feedPattern(256, 13);
    enterRead();
    for (int s = 0; s < 3; s++) begin
      codeA[s] = eccByte;
      pulseRead();
    end
    startChunk();
    for (int i = 0; i < 256; i++) begin
      logic [7:0] b;
      b = pat(i, 13);
      if (i == 100) b[5] = ~b[5];
      sendByte(b, 1'b0, 1'b0);
      refAdd(b);
    end
    enterRead();
    for (int s = 0; s < 3; s++) begin
      codeB[s] = eccByte;
      check("R11 flipped chunk code", eccByte, expByte(0, s));
      pulseRead();
    end
    diff = $countones(codeA[0] ^ codeB[0]) + $countones(codeA[1] ^ codeB[1])
         + $countones(codeA[2] ^ codeB[2]);
    check("R11 changed parity bits", 8'(diff), 8'd11);
    setMode(2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFullPage();
    testPartial();
    testIgnored();
    testStrayRead();
    testClearMidRead();
    testSingleFlip();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule